// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block divides its input clock into a square wave at a programmable rate. Software loads a 16-bit time constant as two bytes, low and high, through separate write strobes. While the enable is high, a down counter steps from the time constant to zero and then takes one further cycle to reload. Every reload inverts the output flip-flop. Each half period therefore lasts TC + 2 input cycles, and a full period lasts 2 x (TC + 2).

For a wanted bit rate, TC = f_clk / (2 x rate) - 2. The block does not synchronise byte writes to the counter. Software should drop the enable while it writes both bytes, so that a reload cannot pick up a half-written constant. A new constant never alters a count that is already running. It is picked up at the next reload. When the enable is low, the counter and the output both hold their values. When the enable goes high again, the counter first loads the constant and only then starts counting. There is no data stream at this block's edge, so it has no valid/ready pins and no back-pressure. All pins are plain control pins.

Top module: `brg_top`

## Requirements
- R1: During and after reset, brg_out is 0 and both time-constant bytes are 0.
- R2: A pulse on wr_lo stores wr_data as bits 7:0 of the time constant, and a pulse on wr_hi stores it as bits 15:8. Writing one byte leaves the other byte unchanged.
- R3: While en stays high, brg_out toggles every TC + 2 clock cycles, giving equal high and low halves and a full period of 2 x (TC + 2).
- R4: With TC = 0, brg_out toggles every 2 clock cycles.
- R5: Writing the time constant while the counter runs does not change the half period in progress. The new value sets the length of the next half period.
- R6: While en is low, brg_out holds its level and the count holds.
- R7: On the first enabled cycle after en was low, the counter loads the time constant. The first toggle therefore comes TC + 3 clock edges after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that drives the counter |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Generator enable |
| wr_lo | input | 1 | Strobe that writes the time-constant low byte |
| wr_hi | input | 1 | Strobe that writes the time-constant high byte |
| wr_data | input | BYTE_W | Byte written by either strobe |
| brg_out | output | 1 | Square-wave output |

## Verification
The bench builds the block with the default BYTE_W of 8, which gives a full 16-bit time constant. It sweeps every TC from 0 to 40 and measures the first interval after enable as well as two following half periods. It adds constants that use the high byte, such as 261 and 511, which exercise the byte assembly and the wider counter within a short run. It also writes a new constant mid-count and toggles the enable mid-count, so that the reload timing and the hold behaviour are measured directly at brg_out.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [0:0] {
    TC_BYTE_LO = 1'b0,
    TC_BYTE_HI = 1'b1
  } tc_byte_e;

  localparam int unsigned TC_BYTES = 2;
endpackage

// File: rtl/brg_tc_regs.sv
module brg_tc_regs
  import brg_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned TC_W = BYTE_W * TC_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TC_BYTES-1:0] wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [TC_W-1:0]   tc
);
  for (genvar b = 0; b < TC_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         byte_q <= '0;
      else if (wr_stb[b]) byte_q <= wr_data;
    end
    assign tc[b*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/brg_down_counter.sv
module brg_down_counter #(
  parameter int unsigned TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [TC_W-1:0] tc,
  output logic [TC_W-1:0] cnt,
  output logic            armed,
  output logic            reload_ph,
  output logic            reload_fire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      armed     <= 1'b0;
      reload_ph <= 1'b0;
    end else if (!en) begin
      armed <= 1'b0;
    end else if (!armed) begin
      cnt       <= tc;
      armed     <= 1'b1;
      reload_ph <= 1'b0;
    end else if (reload_ph) begin
      cnt       <= tc;
      reload_ph <= 1'b0;
    end else if (cnt == '0) begin
      reload_ph <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign reload_fire = en & armed & reload_ph;
endmodule

// File: rtl/brg_toggle.sv
module brg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (flip) q <= ~q;
  end
endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned TC_W = BYTE_W * TC_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              brg_out
);
  logic [TC_BYTES-1:0] wr_stb;
  logic [TC_W-1:0]     tc_val;
  logic [TC_W-1:0]     cnt_q;
  logic                armed_q;
  logic                reload_q;
  logic                fire;

  always_comb begin
    wr_stb             = '0;
    wr_stb[TC_BYTE_LO] = wr_lo;
    wr_stb[TC_BYTE_HI] = wr_hi;
  end

  brg_tc_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .tc(tc_val)
  );

  brg_down_counter #(.TC_W(TC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tc(tc_val), .cnt(cnt_q),
    .armed(armed_q), .reload_ph(reload_q), .reload_fire(fire)
  );

  brg_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .flip(fire), .q(brg_out)
  );
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int unsigned TC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            brg_out,
  input logic [TC_W-1:0] tc_val,
  input logic [TC_W-1:0] cnt_q,
  input logic            armed_q,
  input logic            reload_q
);
  // R3: the output changes exactly on a reload cycle
  p_flip_on_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && armed_q && reload_q) |=> (brg_out != $past(brg_out)));
  p_steady_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && armed_q && reload_q) |=> $stable(brg_out));

  // R5: a running count steps down by one whatever the constant does
  p_count_ignores_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && armed_q && !reload_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6: disabled means frozen
  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(brg_out) && $stable(cnt_q)));

  // R7: first enabled cycle loads the constant
  p_load_on_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !armed_q) |=> (cnt_q == $past(tc_val) && !reload_q));
endmodule

bind brg_top brg_checker #(.TC_W(TC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .brg_out(brg_out),
  .tc_val(tc_val), .cnt_q(cnt_q), .armed_q(armed_q), .reload_q(reload_q)
);

// File: tb/brg_top_tb.sv
`timescale 1ns/1ps
module brg_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_lo = 1'b0;
  logic       wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic       brg_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  brg_top u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .brg_out(brg_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input bit hi, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    if (hi) wr_hi = 1'b1; else wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0;
    wr_hi = 1'b0;
  endtask

  // counts negedges until brg_out changes; optional low-byte write at wr_at
  task automatic measure(output int n, input int wr_at, input logic [7:0] d);
    logic prev;
    prev = brg_out;
    n = 0;
    while (brg_out == prev && n < 3000) begin
      @(negedge clk);
      wr_lo = 1'b0;
      n++;
      if (n == wr_at) begin
        wr_data = d;
        wr_lo = 1'b1;
      end
    end
    wr_lo = 1'b0;
  endtask

  task automatic run_tc(input int tc, input string req);
    int n;
    @(negedge clk);
    en = 1'b0;
    write_byte(1'b0, tc[7:0]);
    write_byte(1'b1, tc[15:8]);
    en = 1'b1;
    measure(n, 0, 8'h0);
    check("R7", n, tc + 3);
    measure(n, 0, 8'h0);
    check(req, n, tc + 2);
    measure(n, 0, 8'h0);
    check(req, n, tc + 2);
    en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    logic lvl;
    repeat (3) @(negedge clk);
    check("R1", brg_out, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1", brg_out, 0);
    // R1: constant reads back as 0 through its period (toggle every 2)
    en = 1'b1;
    measure(n, 0, 8'h0);
    check("R1", n, 3);
    en = 1'b0;

    // R4 and R3 sweep
    run_tc(0, "R4");
    for (int t = 1; t <= 40; t++) run_tc(t, "R3");

    // R2: high byte assembly, then high-only rewrite keeps low byte
    run_tc(261, "R2");
    run_tc(511, "R2");
    @(negedge clk);
    write_byte(1'b0, 8'd5);
    write_byte(1'b1, 8'd1);
    write_byte(1'b1, 8'd0);
    en = 1'b1;
    measure(n, 0, 8'h0);
    check("R2", n, 8);
    measure(n, 0, 8'h0);
    check("R2", n, 7);
    en = 1'b0;

    // R5: rewrite mid-count; current half keeps old length
    @(negedge clk);
    write_byte(1'b0, 8'd20);
    en = 1'b1;
    measure(n, 0, 8'h0);
    check("R7", n, 23);
    measure(n, 6, 8'd3);
    check("R5", n, 22);
    measure(n, 0, 8'h0);
    check("R5", n, 5);

    // R6: disable mid-count, output and level hold
    repeat (2) @(negedge clk);
    en = 1'b0;
    lvl = brg_out;
    repeat (60) @(negedge clk);
    check("R6", brg_out, lvl);
    en = 1'b1;
    measure(n, 0, 8'h0);
    check("R7", n, 6);
    measure(n, 0, 8'h0);
    check("R3", n, 5);
    en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule